// File: doc/BRIEF.md
# Two-Class Memory Channel Arbiter

This block sits in front of a shared memory channel and decides, each cycle the channel is free, which single transaction goes out next. Traffic arrives in two classes. The first class is native DRAM requests. The second is storage-derived requests bound for a flash-backed module. Each class is held in its own queue, so a backlog of slow storage transactions never occupies slots that DRAM requests need. Every queue slot has a ready flag supplied from outside. Slot 0 is always the oldest live entry, and a granted entry is removed from the middle of its queue without disturbing the age order of the rest.

When only one class has a ready entry, that class wins. When both do, the block forms a signed score: the weight times the criticality difference, plus the complement of the weight times the occupancy-stage difference, with the DRAM value taken first in each difference. DRAM wins when the score is zero or positive. No divider is used. Occupancy is turned into a stage by comparing the count against five byte-wide thresholds. Criticality is read from a per-class eight-entry byte table, indexed by an externally supplied 3-bit performance code. The weight is a 5-bit value counted in sixteenths. All thresholds, table entries and the weight sit behind a small byte-wide write port and return to their defaults on reset.

Top module: `hetero_chan_arb`

## Requirements
- R1: The two classes use separate queues. A full storage queue neither blocks DRAM enqueue nor delays a DRAM grant that wins arbitration.
- R2: Within a class, the entry granted is the ready entry at the lowest position, where position 0 is the oldest live entry. After a grant, the remaining entries keep their relative age order.
- R3: When both classes have a ready entry, the score is SR = w·(Cd − Cn) + (16 − w)·(Ud − Un), where C is criticality, U is occupancy stage and w is the weight in sixteenths. DRAM is granted when SR > 0, and the storage class is granted when SR < 0.
- R4: When both classes are ready and SR = 0, DRAM is granted.
- R5: The occupancy stage is the number of the class's five thresholds that the pending count is at or above. By default threshold k (k = 1..5) is ceil(k·DEPTH/6), which gives stage = min(5, floor(6·count/DEPTH)).
- R6: Criticality is the byte in the class's 8-entry table selected by the class's 3-bit performance code. By default, entry i holds i.
- R7: The weight is 5 bits and defaults to 8. A written value above 16 is stored as 16.
- R8: No grant is issued for a cycle in which chan_busy is high. At most one transaction is granted per cycle. A grant decided at a clock edge appears on gnt_valid, gnt_nv and gnt_data after that edge.
- R9: A queue holding DEPTH entries drives its enqueue-ready output low. A push presented while that output is low is dropped.
- R10: Configuration write addresses are: 0–4 DRAM thresholds k=1..5, 8–12 storage thresholds, 16–23 DRAM criticality entries, 24–31 storage criticality entries, 32 weight. A write affects decisions from the next cycle. Reset restores all defaults.
- R11: Ready flags at positions at or beyond a queue's current count are ignored.
- R12: With no ready entry in either class, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_push | input | 1 | Enqueue strobe, DRAM class |
| d_push_data | input | DW | Transaction enqueued into the DRAM queue |
| d_enq_rdy | output | 1 | DRAM queue can accept a push |
| d_rdy | input | DEPTH | Per-position ready flags, DRAM queue (bit 0 = oldest) |
| d_perf | input | 3 | Performance stage code, DRAM class |
| n_push | input | 1 | Enqueue strobe, storage class |
| n_push_data | input | DW | Transaction enqueued into the storage queue |
| n_enq_rdy | output | 1 | Storage queue can accept a push |
| n_rdy | input | DEPTH | Per-position ready flags, storage queue (bit 0 = oldest) |
| n_perf | input | 3 | Performance stage code, storage class |
| chan_busy | input | 1 | Channel occupied; blocks grants |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration write address |
| cfg_data | input | 8 | Configuration write data |
| gnt_valid | output | 1 | A transaction was granted |
| gnt_nv | output | 1 | Granted class: 1 = storage, 0 = DRAM |
| gnt_data | output | DW | Granted transaction |

## Verification
The hardest situation to reach is a contest decided by the occupancy term. The stage only moves after tens of pushes, and the score must land exactly on zero, or on the side that a clamped weight reverses. Each table vector therefore resets the block, loads the weight, fills both queues to chosen counts while chan_busy holds off grants, and then opens the channel for a single cycle. A directed test fills the storage queue to capacity, offers one extra push, and drains everything, so the dropped entry would surface if it had been stored.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

    localparam int STAGES    = 6;
    localparam int NTHR      = STAGES - 1;
    localparam int PERF_W    = 3;
    localparam int CRIT_N    = 1 << PERF_W;
    localparam int WGT_W     = 5;
    localparam int WGT_ONE   = 16;
    localparam int SR_W      = 16;
    localparam int CFG_AW    = 6;
    localparam int UTIL_W    = 3;

    typedef enum logic {
        CLS_DRAM = 1'b0,
        CLS_NV   = 1'b1
    } cls_e;

    localparam logic [CFG_AW-1:0] CFG_WGT_ADDR = 6'd32;

    // default threshold for stage k: ceil(k*depth/STAGES)
    function automatic logic [7:0] dflt_thr(input int k, input int depth);
        return 8'((k * depth + STAGES - 1) / STAGES);
    endfunction

    // clamp a raw written weight to the unit value
    function automatic logic [WGT_W-1:0] clamp_wgt(input logic [7:0] raw);
        return (raw > 8'(WGT_ONE)) ? WGT_W'(WGT_ONE) : raw[WGT_W-1:0];
    endfunction

endpackage

// File: rtl/arb_queue.sv
`timescale 1ns/1ps
module arb_queue #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    output logic             enq_rdy,
    input  logic [DEPTH-1:0] rdy_in,
    input  logic             pop,
    output logic             any_rdy,
    output logic [DW-1:0]    pick_data,
    output logic [CW-1:0]    cnt
);

    logic [DW-1:0]    mem [DEPTH];
    logic [DW-1:0]    nxt [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [DEPTH-1:0] eff;
    logic [IW-1:0]    sel;
    logic             do_push;
    logic [CW-1:0]    wr_pos;

    assign cnt     = cnt_q;
    assign enq_rdy = (cnt_q != CW'(DEPTH));
    assign do_push = push && enq_rdy;
    assign wr_pos  = cnt_q - CW'(pop);

    // ready flags only count for live positions
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            eff[i] = rdy_in[i] && (i < int'(cnt_q));
        end
    end

    // lowest live ready position is the oldest ready entry
    always_comb begin
        sel = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eff[i]) sel = IW'(i);
        end
    end

    assign any_rdy   = |eff;
    assign pick_data = mem[sel];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_shift
            if (g < DEPTH - 1) begin : g_mid
                assign nxt[g] = mem[g + 1];
            end else begin : g_last
                assign nxt[g] = mem[g];
            end
        end
    endgenerate

    // collapse over the removed slot, then append at the new tail
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && i >= int'(sel)) mem[i] <= nxt[i];
            if (do_push && i == int'(wr_pos)) mem[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(do_push) - CW'(pop);
        end
    end

endmodule

// File: rtl/arb_cfg.sv
`timescale 1ns/1ps
module arb_cfg
    import arb_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [7:0]          cfg_data,
    input  logic [CW-1:0]       d_cnt,
    input  logic [CW-1:0]       n_cnt,
    input  logic [PERF_W-1:0]   d_perf,
    input  logic [PERF_W-1:0]   n_perf,
    output logic [UTIL_W-1:0]   d_util,
    output logic [UTIL_W-1:0]   n_util,
    output logic [7:0]          d_crit,
    output logic [7:0]          n_crit,
    output logic [WGT_W-1:0]    wgt
);

    logic [7:0]       thr  [2][NTHR];
    logic [7:0]       crit [2][CRIT_N];
    logic [WGT_W-1:0] wgt_q;

    logic       is_wgt;
    logic       is_crit;
    logic       wr_cls;
    logic [2:0] wr_idx;

    assign is_wgt  = (cfg_addr == CFG_WGT_ADDR);
    assign is_crit = !cfg_addr[5] && cfg_addr[4];
    assign wr_cls  = cfg_addr[3];
    assign wr_idx  = cfg_addr[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < NTHR; k++) thr[c][k] <= dflt_thr(k + 1, DEPTH);
                for (int e = 0; e < CRIT_N; e++) crit[c][e] <= 8'(e);
            end
            wgt_q <= WGT_W'(WGT_ONE / 2);
        end else if (cfg_we) begin
            if (is_wgt) begin
                wgt_q <= clamp_wgt(cfg_data);
            end else if (is_crit) begin
                crit[wr_cls][wr_idx] <= cfg_data;
            end else if (!cfg_addr[5] && int'(wr_idx) < NTHR) begin
                thr[wr_cls][wr_idx] <= cfg_data;
            end
        end
    end

    // threshold compare replaces count / depth
    always_comb begin
        d_util = '0;
        n_util = '0;
        for (int k = 0; k < NTHR; k++) begin
            if (int'(d_cnt) >= int'(thr[CLS_DRAM][k])) d_util = d_util + UTIL_W'(1);
            if (int'(n_cnt) >= int'(thr[CLS_NV][k]))   n_util = n_util + UTIL_W'(1);
        end
    end

    assign d_crit = crit[CLS_DRAM][d_perf];
    assign n_crit = crit[CLS_NV][n_perf];
    assign wgt    = wgt_q;

endmodule

// File: rtl/arb_ratio.sv
`timescale 1ns/1ps
module arb_ratio
    import arb_pkg::*;
(
    input  logic [7:0]        d_crit,
    input  logic [7:0]        n_crit,
    input  logic [UTIL_W-1:0] d_util,
    input  logic [UTIL_W-1:0] n_util,
    input  logic [WGT_W-1:0]  wgt,
    output logic              favor_dram
);

    logic signed [SR_W-1:0] c_diff;
    logic signed [SR_W-1:0] u_diff;
    logic signed [SR_W-1:0] w_a;
    logic signed [SR_W-1:0] w_b;
    logic signed [SR_W-1:0] score;

    always_comb begin
        c_diff = $signed({{(SR_W-8){1'b0}}, d_crit}) - $signed({{(SR_W-8){1'b0}}, n_crit});
        u_diff = $signed({{(SR_W-UTIL_W){1'b0}}, d_util}) - $signed({{(SR_W-UTIL_W){1'b0}}, n_util});
        w_a    = $signed({{(SR_W-WGT_W){1'b0}}, wgt});
        w_b    = $signed(SR_W'(WGT_ONE)) - w_a;
        score  = w_a * c_diff + w_b * u_diff;
        // SRd > SRn with SRn = -SRd reduces to a sign test; zero goes to DRAM
        favor_dram = (score >= 0);
    end

endmodule

// File: rtl/hetero_chan_arb.sv
`timescale 1ns/1ps
module hetero_chan_arb
    import arb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_push,
    input  logic [DW-1:0]     d_push_data,
    output logic              d_enq_rdy,
    input  logic [DEPTH-1:0]  d_rdy,
    input  logic [2:0]        d_perf,
    input  logic              n_push,
    input  logic [DW-1:0]     n_push_data,
    output logic              n_enq_rdy,
    input  logic [DEPTH-1:0]  n_rdy,
    input  logic [2:0]        n_perf,
    input  logic              chan_busy,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [7:0]        cfg_data,
    output logic              gnt_valid,
    output logic              gnt_nv,
    output logic [DW-1:0]     gnt_data
);

    logic              d_any, n_any;
    logic [DW-1:0]     d_pick, n_pick;
    logic [CW-1:0]     d_cnt, n_cnt;
    logic              d_pop, n_pop;
    logic [UTIL_W-1:0] d_util, n_util;
    logic [7:0]        d_crit, n_crit;
    logic [WGT_W-1:0]  wgt;
    logic              favor_dram;

    arb_queue #(.DEPTH(DEPTH), .DW(DW)) u_dq (
        .clk(clk), .rst(rst),
        .push(d_push), .push_data(d_push_data), .enq_rdy(d_enq_rdy),
        .rdy_in(d_rdy), .pop(d_pop),
        .any_rdy(d_any), .pick_data(d_pick), .cnt(d_cnt)
    );

    arb_queue #(.DEPTH(DEPTH), .DW(DW)) u_nq (
        .clk(clk), .rst(rst),
        .push(n_push), .push_data(n_push_data), .enq_rdy(n_enq_rdy),
        .rdy_in(n_rdy), .pop(n_pop),
        .any_rdy(n_any), .pick_data(n_pick), .cnt(n_cnt)
    );

    arb_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .d_cnt(d_cnt), .n_cnt(n_cnt), .d_perf(d_perf), .n_perf(n_perf),
        .d_util(d_util), .n_util(n_util), .d_crit(d_crit), .n_crit(n_crit),
        .wgt(wgt)
    );

    arb_ratio u_ratio (
        .d_crit(d_crit), .n_crit(n_crit),
        .d_util(d_util), .n_util(n_util),
        .wgt(wgt), .favor_dram(favor_dram)
    );

    // a lone ready class wins outright; a contest goes to the score
    assign d_pop = !chan_busy && d_any && (!n_any || favor_dram);
    assign n_pop = !chan_busy && n_any && !d_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_nv    <= 1'b0;
            gnt_data  <= '0;
        end else begin
            gnt_valid <= d_pop || n_pop;
            gnt_nv    <= n_pop;
            if (d_pop || n_pop) gnt_data <= n_pop ? n_pick : d_pick;
        end
    end

endmodule

// File: rtl/hetero_chan_arb_chk.sv
`timescale 1ns/1ps
module hetero_chan_arb_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          chan_busy,
    input logic          gnt_valid,
    input logic          d_any,
    input logic          n_any,
    input logic          d_pop,
    input logic          n_pop,
    input logic          d_push,
    input logic          d_enq_rdy,
    input logic          n_enq_rdy,
    input logic [CW-1:0] d_cnt,
    input logic [CW-1:0] n_cnt
);

    // R8: busy channel yields no grant
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        chan_busy |=> !gnt_valid);

    // R8: at most one class popped per cycle
    a_r8_single_pop: assert property (@(posedge clk) disable iff (rst)
        $onehot0({d_pop, n_pop}));

    // R12: nothing ready means nothing granted
    a_r12_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (!d_any && !n_any) |=> !gnt_valid);

    // R9: occupancy never exceeds the queue size
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(d_cnt) <= DEPTH) && (int'(n_cnt) <= DEPTH));

    // R9: a full queue without a pop keeps its count
    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (!n_enq_rdy && !n_pop) |=> $stable(n_cnt));

    // R2: a pop with no push shrinks the queue by one
    a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (d_pop && !d_push) |=> (d_cnt == $past(d_cnt) - CW'(1)));

    // R9: enqueue-ready tracks fullness
    a_r9_rdy_full: assert property (@(posedge clk) disable iff (rst)
        d_enq_rdy == (int'(d_cnt) != DEPTH));

endmodule

bind hetero_chan_arb hetero_chan_arb_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .chan_busy(chan_busy), .gnt_valid(gnt_valid),
    .d_any(d_any), .n_any(n_any), .d_pop(d_pop), .n_pop(n_pop),
    .d_push(d_push), .d_enq_rdy(d_enq_rdy), .n_enq_rdy(n_enq_rdy),
    .d_cnt(d_cnt), .n_cnt(n_cnt)
);

// File: tb/hetero_chan_arb_tb.sv
`timescale 1ns/1ps
module hetero_chan_arb_tb;

    localparam int DEPTH = 128;
    localparam int DW    = 32;
    localparam logic [DW-1:0] DBASE = 32'hD000_0000;
    localparam logic [DW-1:0] NBASE = 32'hA000_0000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             d_push = 1'b0, n_push = 1'b0;
    logic [DW-1:0]    d_push_data = '0, n_push_data = '0;
    logic             d_enq_rdy, n_enq_rdy;
    logic [DEPTH-1:0] d_rdy = '0, n_rdy = '0;
    logic [2:0]       d_perf = '0, n_perf = '0;
    logic             chan_busy = 1'b1;
    logic             cfg_we = 1'b0;
    logic [5:0]       cfg_addr = '0;
    logic [7:0]       cfg_data = '0;
    logic             gnt_valid, gnt_nv;
    logic [DW-1:0]    gnt_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    hetero_chan_arb #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .d_push(d_push), .d_push_data(d_push_data), .d_enq_rdy(d_enq_rdy),
        .d_rdy(d_rdy), .d_perf(d_perf),
        .n_push(n_push), .n_push_data(n_push_data), .n_enq_rdy(n_enq_rdy),
        .n_rdy(n_rdy), .n_perf(n_perf),
        .chan_busy(chan_busy),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .gnt_valid(gnt_valid), .gnt_nv(gnt_nv), .gnt_data(gnt_data)
    );

    typedef struct packed {
        logic [7:0] nd;
        logic [7:0] nn;
        logic [7:0] md;
        logic [7:0] mn;
        logic [2:0] pd;
        logic [2:0] pn;
        logic [7:0] w;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  8'd0,   8'h0F, 8'h00, 3'd3, 3'd7, 8'd8},   // R2 DRAM only
        '{8'd0,  8'd5,   8'h00, 8'h1C, 3'd0, 3'd0, 8'd8},   // R2 storage only, oldest ready at 2
        '{8'd3,  8'd3,   8'h04, 8'h02, 3'd2, 3'd2, 8'd8},   // R4 tie
        '{8'd3,  8'd3,   8'h01, 8'h01, 3'd1, 3'd4, 8'd8},   // R3 criticality to storage
        '{8'd50, 8'd3,   8'h01, 8'h01, 3'd4, 3'd4, 8'd0},   // R5 occupancy to DRAM
        '{8'd3,  8'd50,  8'h01, 8'h01, 3'd7, 3'd0, 8'd0},   // R5 occupancy to storage
        '{8'd3,  8'd50,  8'h01, 8'h01, 3'd7, 3'd0, 8'd16},  // R6 pure criticality
        '{8'd3,  8'd50,  8'h01, 8'h01, 3'd5, 3'd4, 8'd8},   // R3 mixed
        '{8'd2,  8'd2,   8'hF0, 8'h01, 3'd7, 3'd0, 8'd8},   // R11 flags past count
        '{8'd45, 8'd23,  8'h80, 8'h40, 3'd3, 3'd4, 8'd8},   // R4 zero score from mixed terms
        '{8'd2,  8'd2,   8'h00, 8'h00, 3'd0, 3'd0, 8'd8},   // R12 nothing ready
        '{8'd3,  8'd100, 8'h01, 8'h01, 3'd4, 3'd5, 8'd31}   // R7 clamp decides
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        chan_busy = 1'b1;
        d_push = 1'b0; n_push = 1'b0; cfg_we = 1'b0;
        d_rdy = '0; n_rdy = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [7:0] v);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic fill(input int nd, input int nn);
        int top = (nd > nn) ? nd : nn;
        for (int i = 0; i < top; i++) begin
            d_push = (i < nd); d_push_data = DBASE + DW'(i);
            n_push = (i < nn); n_push_data = NBASE + DW'(i);
            tick();
        end
        d_push = 1'b0; n_push = 1'b0;
    endtask

    task automatic open_once();
        chan_busy = 1'b0;
        tick();
        chan_busy = 1'b1;
    endtask

    function automatic int stage_of(input int c);
        int s = (c * 6) / DEPTH;
        return (s > 5) ? 5 : s;
    endfunction

    function automatic int oldest(input int cnt, input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i] && i < cnt) return i;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // R9 R8: reset state
        check(d_enq_rdy && n_enq_rdy, "R9", "enq_rdy after reset",
              {d_enq_rdy, n_enq_rdy}, 2'b11);
        check(!gnt_valid, "R8", "gnt_valid after reset", gnt_valid, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int di, ni, wc, sr;
            bit ev, enb;
            logic [DW-1:0] ed;
            do_reset();
            cfg_write(6'd32, VECS[v].w);
            fill(int'(VECS[v].nd), int'(VECS[v].nn));
            d_rdy = {{(DEPTH-8){1'b0}}, VECS[v].md};
            n_rdy = {{(DEPTH-8){1'b0}}, VECS[v].mn};
            d_perf = VECS[v].pd; n_perf = VECS[v].pn;
            di = oldest(int'(VECS[v].nd), VECS[v].md);
            ni = oldest(int'(VECS[v].nn), VECS[v].mn);
            wc = (int'(VECS[v].w) > 16) ? 16 : int'(VECS[v].w);
            sr = wc * (int'(VECS[v].pd) - int'(VECS[v].pn))
               + (16 - wc) * (stage_of(int'(VECS[v].nd)) - stage_of(int'(VECS[v].nn)));
            ev  = (di >= 0) || (ni >= 0);
            enb = (ni >= 0) && ((di < 0) || (sr < 0));
            ed  = enb ? NBASE + DW'(ni) : DBASE + DW'(di);
            open_once();
            check(gnt_valid == ev, "R3", $sformatf("vector %0d valid", v), gnt_valid, ev);
            if (ev) begin
                check(gnt_nv == enb, "R3", $sformatf("vector %0d class", v), gnt_nv, enb);
                check(gnt_data == ed, "R2", $sformatf("vector %0d data", v), gnt_data, ed);
            end
        end

        // R8: busy held with ready entries -> no grant
        do_reset();
        fill(2, 2);
        d_rdy = '1; n_rdy = '1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check(!gnt_valid, "R8", "grant under busy", gnt_valid, 0);
        end

        // R2: removal from the middle keeps age order
        do_reset();
        fill(4, 0);
        d_rdy = '1; open_once();
        check(gnt_data == DBASE, "R2", "first pick", gnt_data, DBASE);
        d_rdy = {{(DEPTH-2){1'b0}}, 2'b10}; open_once();
        check(gnt_data == DBASE + 2, "R2", "middle pick", gnt_data, DBASE + 2);
        d_rdy = '1; open_once();
        check(gnt_data == DBASE + 1, "R2", "after collapse 1", gnt_data, DBASE + 1);
        open_once();
        check(gnt_data == DBASE + 3, "R2", "after collapse 2", gnt_data, DBASE + 3);
        open_once();
        check(!gnt_valid, "R12", "empty queue grant", gnt_valid, 0);

        // R6 R10: storage criticality entry 2 set to 200 flips a tie
        do_reset();
        cfg_write(6'd26, 8'd200);
        fill(3, 3);
        d_perf = 3'd2; n_perf = 3'd2;
        d_rdy = '1; n_rdy = '1;
        open_once();
        check(gnt_valid && gnt_nv, "R10", "crit table write", gnt_nv, 1);

        // R5 R10: storage threshold 1 set to 1 with weight 0
        do_reset();
        cfg_write(6'd32, 8'd0);
        cfg_write(6'd8, 8'd1);
        fill(1, 1);
        d_perf = 3'd0; n_perf = 3'd0;
        d_rdy = '1; n_rdy = '1;
        open_once();
        check(gnt_valid && gnt_nv, "R5", "threshold write", gnt_nv, 1);

        // R10: reset restores defaults (same contest now ties -> DRAM)
        do_reset();
        fill(1, 1);
        d_rdy = '1; n_rdy = '1;
        open_once();
        check(gnt_valid && !gnt_nv, "R10", "defaults after reset", gnt_nv, 0);

        // R1 R9: full storage queue, dropped push, DRAM still served
        do_reset();
        cfg_write(6'd32, 8'd16);
        fill(0, DEPTH);
        check(!n_enq_rdy, "R9", "storage full", n_enq_rdy, 0);
        check(d_enq_rdy, "R1", "DRAM open while storage full", d_enq_rdy, 1);
        n_push = 1'b1; n_push_data = 32'h0000_0BAD;
        tick();
        n_push = 1'b0;
        fill(2, 0);
        d_perf = 3'd7; n_perf = 3'd0;
        d_rdy = '1; n_rdy = '1;
        chan_busy = 1'b0;
        tick();
        check(gnt_valid && !gnt_nv && gnt_data == DBASE, "R1", "DRAM first", gnt_data, DBASE);
        tick();
        check(gnt_valid && !gnt_nv && gnt_data == DBASE + 1, "R1", "DRAM second", gnt_data, DBASE + 1);
        begin
            int bad = 0;
            logic [DW-1:0] first_bad_act = '0, first_bad_exp = '0;
            for (int k = 0; k < DEPTH; k++) begin
                tick();
                if (!(gnt_valid && gnt_nv && gnt_data == NBASE + DW'(k))) begin
                    if (bad == 0) begin
                        first_bad_act = gnt_data;
                        first_bad_exp = NBASE + DW'(k);
                    end
                    bad++;
                end
            end
            check(bad == 0, "R2", "storage drain order", first_bad_act, first_bad_exp);
        end
        tick();
        check(!gnt_valid, "R9", "dropped push never granted", gnt_valid, 0);
        chan_busy = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule